// File: doc/BRIEF.md
# Interrupt Source State Controller

This block holds the per-source state of a set of interrupt sources. Their global numbers start at a fixed base. Each source is wired as either level-triggered or message-triggered. For every source the block stores a target server, a live priority, a saved priority and four status flags. It turns source events and configuration commands into delivery requests to a single presentation controller. It reacts to that controller's reject, end-of-interrupt and resend notifications. A priority of 0xFF means the source is masked.

The presentation controller answers each delivery request in the same cycle by driving `dlv_rej`. The controller can also reject a source it had already accepted, at any later time, through the separate reject port. A resend request starts a scan. The scan visits one source per cycle and gives way to any other operation presented in that cycle. The server field is stored and reported, but it plays no part in routing.

Top module: `irq_source_ctrl`

## Requirements
- R1: After reset, every source has priority 0xFF, saved priority 0xFF and server 0, with all four flags clear. `busy` is low and no delivery is requested. A message event that arrived while masked before the reset is not replayed afterwards.
- R2: Global number n is valid when BASE <= n < BASE+NSRC, and its local index is n-BASE. A delivery carries global number BASE+index. A command naming a number outside the valid range answers with status 0xFD.
- R3: A message event with `ev_level`=1 on a source whose priority is 0xFF requests no delivery and records a pending event. On any other priority it requests delivery in the same cycle, carrying the source's priority. No delivery ever carries priority 0xFF.
- R4: A level event copies `ev_level` into the asserted flag. A delivery is requested in that cycle only when the priority is not 0xFF, the line is asserted and the source has no delivery outstanding; the source is then marked outstanding. Repeated asserts while outstanding deliver nothing.
- R5: A rejection clears the outstanding mark and sets the rejected mark. It can arrive on the reject port or as `dlv_rej` during a delivery. A level source that is still asserted therefore delivers again on its next event.
- R6: A pulse on `resend_req` raises `busy` in the next cycle. The scan then examines sources 0 to NSRC-1, one per free cycle, and `busy` falls after the last one. A level source is re-checked as in R4. A rejected message source has its rejected mark cleared and is delivered again if its priority is not 0xFF.
- R7: End-of-interrupt clears the outstanding mark of a level source, without delivering anything by itself. On a message source it changes nothing; in particular, a rejected mark survives it.
- R8: Command code 0 (set) stores the server and the priority into both priority fields. A message source with a pending event is then delivered, and the pending event is cleared, if the new priority is not 0xFF. A level source is re-checked as in R4. Each accepted command answers in the next cycle with `rsp_valid`, status 0x00 and the resulting server and priority. Code 1 (get) reports them without changing anything.
- R9: Command code 2 (disable) moves the current priority into the saved field and sets the priority to 0xFF. Command code 3 (enable) copies the saved value back into the priority, and it then replays as in R8.
- R10: A set whose server is at or above NSERV, or whose priority exceeds 0xFF, answers with status 0xFD, server 0 and priority 0. It changes no state.
- R11: Only one operation is taken per cycle, in the order reject, end-of-interrupt, command, event, scan step. A lower operation presented together with a higher one is dropped, so it neither delivers nor answers. A scan step that gives way to another operation is postponed, not skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_is_level | input | NSRC | Per-source type, 1 = level, 0 = message |
| ev_valid | input | 1 | Source event strobe |
| ev_src | input | IDX_W | Local index of the event's source |
| ev_level | input | 1 | Event value (line level or message present) |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 set, 1 get, 2 disable, 3 enable |
| cmd_num | input | NUM_W | Global source number of the command |
| cmd_server | input | SRV_W | Server for set |
| cmd_prio | input | 9 | Priority for set (values above 0xFF are refused) |
| rsp_valid | output | 1 | Command answer strobe, one cycle after the command |
| rsp_status | output | 8 | 0x00 success, 0xFD refused |
| rsp_server | output | SRV_W | Resulting server |
| rsp_prio | output | 8 | Resulting priority |
| dlv_valid | output | 1 | Delivery request |
| dlv_num | output | NUM_W | Global number being delivered |
| dlv_prio | output | 8 | Priority being delivered |
| dlv_rej | input | 1 | Same-cycle rejection of the delivery |
| rej_valid | input | 1 | Later rejection strobe |
| rej_num | input | NUM_W | Global number being rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Global number being completed |
| resend_req | input | 1 | Start (or restart) the resend scan |
| busy | output | 1 | Resend scan in progress |

## Verification
The embedded properties watch the invariants that hold on every cycle. No delivery ever carries priority 0xFF or a number outside the window. An answer appears only one cycle after a command, and a command naming an out-of-range number is refused. A reject or end-of-interrupt suppresses any delivery or answer in its cycle. `busy` rises only after a resend request and falls after the last scan step. The stateful behaviours need the bench's ordered scenarios: a masked message replayed on set or enable, a level source re-presented only after end-of-interrupt or rejection, the order and content of scan deliveries, a scan stalled by an event, and reset discarding pending state.

// File: rtl/irq_source_ctrl.sv
module irq_source_ctrl #(
  parameter int NSRC  = 8,
  parameter int BASE  = 16,
  parameter int NSERV = 4,
  parameter int NUM_W = 12,
  parameter int SRV_W = 8,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_is_level,
  input  logic             ev_valid,
  input  logic [IDX_W-1:0] ev_src,
  input  logic             ev_level,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [NUM_W-1:0] cmd_num,
  input  logic [SRV_W-1:0] cmd_server,
  input  logic [8:0]       cmd_prio,
  output logic             rsp_valid,
  output logic [7:0]       rsp_status,
  output logic [SRV_W-1:0] rsp_server,
  output logic [7:0]       rsp_prio,
  output logic             dlv_valid,
  output logic [NUM_W-1:0] dlv_num,
  output logic [7:0]       dlv_prio,
  input  logic             dlv_rej,
  input  logic             rej_valid,
  input  logic [NUM_W-1:0] rej_num,
  input  logic             eoi_valid,
  input  logic [NUM_W-1:0] eoi_num,
  input  logic             resend_req,
  output logic             busy
);

  localparam logic [7:0] MASKED = 8'hFF;
  localparam logic [7:0] ST_OK  = 8'h00;
  localparam logic [7:0] ST_BAD = 8'hFD;
  localparam logic [1:0] C_SET = 2'd0, C_GET = 2'd1, C_OFF = 2'd2;
  localparam int F_ASRT = 0, F_SENT = 1, F_REJ = 2, F_MPND = 3;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NSRC - 1);

  typedef enum logic [2:0] {OP_IDLE, OP_REJ, OP_EOI, OP_CMD, OP_EV, OP_SCAN} op_e;

  logic [SRV_W-1:0] srv_q [NSRC];
  logic [7:0]       pr_q  [NSRC];
  logic [7:0]       sv_q  [NSRC];
  logic [3:0]       fl_q  [NSRC];
  logic             busy_q;
  logic [IDX_W-1:0] ptr_q;

  function automatic logic num_ok(input logic [NUM_W-1:0] n);
    return (int'({1'b0, n}) >= BASE) && (int'({1'b0, n}) < BASE + NSRC);
  endfunction

  function automatic logic [IDX_W-1:0] to_idx(input logic [NUM_W-1:0] n);
    return IDX_W'(int'({1'b0, n}) - BASE);
  endfunction

  function automatic logic lvl_ready(input logic [7:0] pr, input logic [3:0] fl);
    return (pr != MASKED) && fl[F_ASRT] && !fl[F_SENT];
  endfunction

  op_e              op;
  logic [IDX_W-1:0] tgt;
  logic             tgt_ok;
  logic             cmd_ok;

  always_comb begin
    op     = OP_IDLE;
    tgt    = ptr_q;
    tgt_ok = 1'b1;
    if (rej_valid) begin
      op = OP_REJ;  tgt = to_idx(rej_num);  tgt_ok = num_ok(rej_num);
    end else if (eoi_valid) begin
      op = OP_EOI;  tgt = to_idx(eoi_num);  tgt_ok = num_ok(eoi_num);
    end else if (cmd_valid) begin
      op = OP_CMD;  tgt = to_idx(cmd_num);  tgt_ok = num_ok(cmd_num);
    end else if (ev_valid) begin
      op = OP_EV;   tgt = ev_src;           tgt_ok = int'({1'b0, ev_src}) < NSRC;
    end else if (busy_q && !resend_req) begin
      op = OP_SCAN;
    end
  end

  assign cmd_ok = tgt_ok &&
                  (cmd_op != C_SET || (int'({1'b0, cmd_server}) < NSERV && !cmd_prio[8]));

  logic             is_lvl;
  logic [SRV_W-1:0] cur_srv, nxt_srv;
  logic [7:0]       cur_pr, nxt_pr, cur_sv, nxt_sv;
  logic [3:0]       cur_fl, nxt_fl;
  logic             wr, go;

  assign is_lvl  = src_is_level[tgt];
  assign cur_srv = srv_q[tgt];
  assign cur_pr  = pr_q[tgt];
  assign cur_sv  = sv_q[tgt];
  assign cur_fl  = fl_q[tgt];

  always_comb begin
    nxt_srv = cur_srv;
    nxt_pr  = cur_pr;
    nxt_sv  = cur_sv;
    nxt_fl  = cur_fl;
    wr      = 1'b0;
    go      = 1'b0;
    case (op)
      OP_REJ: if (tgt_ok) begin
        wr = 1'b1;
        nxt_fl[F_REJ]  = 1'b1;
        nxt_fl[F_SENT] = 1'b0;
      end
      OP_EOI: if (tgt_ok && is_lvl) begin
        wr = 1'b1;
        nxt_fl[F_SENT] = 1'b0;
      end
      OP_CMD: if (cmd_ok && cmd_op != C_GET) begin
        wr = 1'b1;
        case (cmd_op)
          C_SET: begin
            nxt_srv = cmd_server;
            nxt_pr  = cmd_prio[7:0];
            nxt_sv  = cmd_prio[7:0];
          end
          C_OFF: begin
            nxt_pr = MASKED;
            nxt_sv = cur_pr;
          end
          default: begin
            nxt_pr = cur_sv;
            nxt_sv = cur_sv;
          end
        endcase
        if (is_lvl) begin
          go = lvl_ready(nxt_pr, nxt_fl);
        end else if (nxt_fl[F_MPND] && nxt_pr != MASKED) begin
          go = 1'b1;
          nxt_fl[F_MPND] = 1'b0;
        end
      end
      OP_EV: if (tgt_ok) begin
        wr = 1'b1;
        if (is_lvl) begin
          nxt_fl[F_ASRT] = ev_level;
          go = lvl_ready(nxt_pr, nxt_fl);
        end else if (ev_level) begin
          if (cur_pr == MASKED) nxt_fl[F_MPND] = 1'b1;
          else                  go = 1'b1;
        end
      end
      OP_SCAN: begin
        wr = 1'b1;
        if (is_lvl) begin
          go = lvl_ready(cur_pr, cur_fl);
        end else if (cur_fl[F_REJ]) begin
          nxt_fl[F_REJ] = 1'b0;
          go = (cur_pr != MASKED);
        end
      end
      default: ;
    endcase
    if (go && is_lvl) nxt_fl[F_SENT] = 1'b1;
    if (go && dlv_rej) begin
      nxt_fl[F_REJ]  = 1'b1;
      nxt_fl[F_SENT] = 1'b0;
    end
  end

  assign dlv_valid = go;
  assign dlv_num   = NUM_W'(BASE) + NUM_W'(tgt);
  assign dlv_prio  = nxt_pr;
  assign busy      = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin
        srv_q[i] <= '0;
        pr_q[i]  <= MASKED;
        sv_q[i]  <= MASKED;
        fl_q[i]  <= '0;
      end
      busy_q     <= 1'b0;
      ptr_q      <= '0;
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_server <= '0;
      rsp_prio   <= 8'h00;
    end else begin
      if (wr) begin
        srv_q[tgt] <= nxt_srv;
        pr_q[tgt]  <= nxt_pr;
        sv_q[tgt]  <= nxt_sv;
        fl_q[tgt]  <= nxt_fl;
      end
      if (resend_req) begin
        busy_q <= 1'b1;
        ptr_q  <= '0;
      end else if (op == OP_SCAN) begin
        if (ptr_q == LAST) busy_q <= 1'b0;
        else               ptr_q  <= ptr_q + 1'b1;
      end
      rsp_valid <= (op == OP_CMD);
      if (op == OP_CMD) begin
        rsp_status <= cmd_ok ? ST_OK : ST_BAD;
        rsp_server <= cmd_ok ? nxt_srv : '0;
        rsp_prio   <= cmd_ok ? nxt_pr : 8'h00;
      end
    end
  end

  assert_dlv_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> dlv_prio != MASKED);

  assert_dlv_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> num_ok(dlv_num));

  assert_rsp_follows_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cmd_valid));

  assert_bad_num_refused_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !rej_valid && !eoi_valid && !num_ok(cmd_num)) |=> rsp_valid && rsp_status == ST_BAD);

  assert_notify_blocks_dlv_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rej_valid || eoi_valid) |-> !dlv_valid);

  assert_notify_blocks_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rej_valid || eoi_valid) |=> !rsp_valid);

  assert_scan_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(resend_req));

  assert_scan_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SCAN && ptr_q == LAST && !resend_req) |=> !busy);

endmodule

// File: tb/irq_source_ctrl_tb.sv
module irq_source_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int NV    = 26;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src_is_level = 8'h0F;
  logic        ev_valid = 1'b0, ev_level = 1'b0;
  logic [2:0]  ev_src = '0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [11:0] cmd_num = '0;
  logic [7:0]  cmd_server = '0;
  logic [8:0]  cmd_prio = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_status, rsp_server, rsp_prio;
  logic        dlv_valid;
  logic [11:0] dlv_num;
  logic [7:0]  dlv_prio;
  logic        dlv_rej = 1'b0;
  logic        rej_valid = 1'b0, eoi_valid = 1'b0;
  logic [11:0] rej_num = '0, eoi_num = '0;
  logic        resend_req = 1'b0;
  logic        busy;

  always #(CLK_P/2) clk = ~clk;

  irq_source_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_is_level(src_is_level),
    .ev_valid(ev_valid), .ev_src(ev_src), .ev_level(ev_level),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_num(cmd_num),
    .cmd_server(cmd_server), .cmd_prio(cmd_prio),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_server(rsp_server), .rsp_prio(rsp_prio),
    .dlv_valid(dlv_valid), .dlv_num(dlv_num), .dlv_prio(dlv_prio), .dlv_rej(dlv_rej),
    .rej_valid(rej_valid), .rej_num(rej_num), .eoi_valid(eoi_valid), .eoi_num(eoi_num),
    .resend_req(resend_req), .busy(busy)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic [1:0]  op;
    logic [11:0] num;
    logic [7:0]  srv;
    logic [8:0]  prio;
    logic        lvl;
    logic        drej;
    logic        edlv;
    logic [11:0] xnum;
    logic [7:0]  eprio;
    logic [7:0]  estat;
    logic [7:0]  esrv;
    logic [7:0]  erprio;
    logic [3:0]  tag;
  } vec_t;

  function automatic vec_t mk(int kind, int op, int num, int srv, int prio, int lvl, int drej,
                              int edlv, int xnum, int eprio, int estat, int esrv, int erprio, int tag);
    vec_t v;
    v.kind = 2'(kind);   v.op = 2'(op);       v.num = 12'(num);    v.srv = 8'(srv);
    v.prio = 9'(prio);   v.lvl = 1'(lvl);     v.drej = 1'(drej);   v.edlv = 1'(edlv);
    v.xnum = 12'(xnum);  v.eprio = 8'(eprio); v.estat = 8'(estat); v.esrv = 8'(esrv);
    v.erprio = 8'(erprio); v.tag = 4'(tag);
    return v;
  endfunction

  function automatic vec_t ev(int src, int lvl, int drej, int edlv, int xnum, int eprio, int tag);
    return mk(0, 0, src, 0, 0, lvl, drej, edlv, xnum, eprio, 0, 0, 0, tag);
  endfunction
  function automatic vec_t cm(int op, int num, int srv, int prio, int edlv, int xnum, int eprio,
                              int estat, int esrv, int erprio, int tag);
    return mk(1, op, num, srv, prio, 0, 0, edlv, xnum, eprio, estat, esrv, erprio, tag);
  endfunction
  function automatic vec_t rj(int num, int tag);
    return mk(2, 0, num, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endfunction
  function automatic vec_t eo(int num, int tag);
    return mk(3, 0, num, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endfunction

  // Sources 0..3 (numbers 16..19) are level, 4..7 (20..23) are message.
  localparam vec_t VEC [NV] = '{
    cm(1, 16, 0, 0,   0, 0, 0,    0, 0, 255, 1),   // R1 reset priority
    ev(4, 1, 0, 0, 0, 0, 3),                        // R3 masked message -> pending
    cm(0, 20, 1, 5,   1, 20, 5,   0, 1, 5, 8),      // R8 set replays pending
    ev(4, 1, 0, 1, 20, 5, 3),                       // R3 immediate delivery
    ev(0, 1, 0, 0, 0, 0, 4),                        // R4 asserted but masked
    cm(0, 16, 2, 3,   1, 16, 3,   0, 2, 3, 8),      // R8 set runs level check
    ev(0, 1, 0, 0, 0, 0, 4),                        // R4 outstanding, no repeat
    eo(16, 7),                                      // R7 EOI on level
    ev(0, 1, 0, 1, 16, 3, 7),                       // R7 re-presented after EOI
    rj(16, 5),                                      // R5 later reject
    ev(0, 1, 0, 1, 16, 3, 5),                       // R5 outstanding cleared by reject
    ev(4, 1, 1, 1, 20, 5, 5),                       // R5 same-cycle reject
    cm(0, 40, 0, 1,   0, 0, 0,    253, 0, 0, 10),   // R10 number out of range
    cm(0, 17, 4, 1,   0, 0, 0,    253, 0, 0, 10),   // R10 server too large
    cm(0, 17, 0, 256, 0, 0, 0,    253, 0, 0, 10),   // R10 priority too large
    cm(1, 17, 0, 0,   0, 0, 0,    0, 0, 255, 10),   // R10 refused set left no trace
    cm(2, 20, 0, 0,   0, 0, 0,    0, 1, 255, 9),    // R9 disable
    ev(4, 1, 0, 0, 0, 0, 9),                        // R9 disabled -> pending
    cm(3, 20, 0, 0,   1, 20, 5,   0, 1, 5, 9),      // R9 enable restores and replays
    cm(1, 24, 0, 0,   0, 0, 0,    253, 0, 0, 2),    // R2 one past the window
    cm(1, 15, 0, 0,   0, 0, 0,    253, 0, 0, 2),    // R2 one below the window
    cm(1, 23, 0, 0,   0, 0, 0,    0, 0, 255, 2),    // R2 last valid number
    ev(1, 1, 0, 0, 0, 0, 4),                        // R4 masked level
    cm(0, 17, 3, 16,  1, 17, 16,  0, 3, 16, 8),     // R8 set delivers asserted level
    eo(20, 7),                                      // R7 EOI on message: no effect
    eo(16, 7)                                       // R7 clears outstanding on 16
  };

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ev_valid = 1'b0; cmd_valid = 1'b0; rej_valid = 1'b0; eoi_valid = 1'b0;
    dlv_rej = 1'b0; resend_req = 1'b0;
  endtask

  task automatic apply(input vec_t v);
    string t;
    t = $sformatf("R%0d", v.tag);
    @(negedge clk);
    case (v.kind)
      2'd0: begin ev_valid = 1'b1; ev_src = v.num[2:0]; ev_level = v.lvl; dlv_rej = v.drej; end
      2'd1: begin cmd_valid = 1'b1; cmd_op = v.op; cmd_num = v.num; cmd_server = v.srv; cmd_prio = v.prio; end
      2'd2: begin rej_valid = 1'b1; rej_num = v.num; end
      default: begin eoi_valid = 1'b1; eoi_num = v.num; end
    endcase
    #(CLK_P/4);
    chk(t, "dlv_valid", 32'(dlv_valid), 32'(v.edlv));
    if (v.edlv) begin
      chk(t, "dlv_num", 32'(dlv_num), 32'(v.xnum));
      chk(t, "dlv_prio", 32'(dlv_prio), 32'(v.eprio));
    end
    @(posedge clk);
    #(CLK_P/4);
    idle_inputs();
    if (v.kind == 2'd1) begin
      chk(t, "rsp_valid", 32'(rsp_valid), 32'd1);
      chk(t, "rsp_status", 32'(rsp_status), 32'(v.estat));
      if (v.estat == 8'h00) begin
        chk(t, "rsp_server", 32'(rsp_server), 32'(v.esrv));
        chk(t, "rsp_prio", 32'(rsp_prio), 32'(v.erprio));
      end
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL all watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #(CLK_P/4);
    chk("R1", "busy in reset", 32'(busy), 32'd0);
    chk("R1", "dlv in reset", 32'(dlv_valid), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) apply(VEC[i]);

    // R6: scan; expect 16/3 at step 0 and 20/5 at step 4
    @(negedge clk);
    resend_req = 1'b1;
    @(posedge clk);
    #(CLK_P/4);
    idle_inputs();
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      #(CLK_P/4);
      chk("R6", "busy during scan", 32'(busy), (k < 8) ? 32'd1 : 32'd0);
      chk("R6", "scan dlv_valid", 32'(dlv_valid), (k == 0 || k == 4) ? 32'd1 : 32'd0);
      if (k == 0) chk("R6", "scan dlv_num", 32'(dlv_num), 32'd16);
      if (k == 4) begin
        chk("R6", "scan dlv_num", 32'(dlv_num), 32'd20);
        chk("R6", "scan dlv_prio", 32'(dlv_prio), 32'd5);
      end
    end

    // R11: reject beats message event
    @(negedge clk);
    rej_valid = 1'b1; rej_num = 12'd17;
    ev_valid = 1'b1; ev_src = 3'd4; ev_level = 1'b1;
    #(CLK_P/4);
    chk("R11", "event dropped under reject", 32'(dlv_valid), 32'd0);
    @(posedge clk);
    #(CLK_P/4);
    idle_inputs();
    // R11: EOI beats command
    @(negedge clk);
    eoi_valid = 1'b1; eoi_num = 12'd16;
    cmd_valid = 1'b1; cmd_op = 2'd1; cmd_num = 12'd20;
    @(posedge clk);
    #(CLK_P/4);
    idle_inputs();
    chk("R11", "command dropped under EOI", 32'(rsp_valid), 32'd0);

    // R11 and R6: scan stalled by an event, deliveries 20, 16, 17
    @(negedge clk);
    resend_req = 1'b1;
    @(posedge clk);
    #(CLK_P/4);
    idle_inputs();
    @(negedge clk);
    ev_valid = 1'b1; ev_src = 3'd4; ev_level = 1'b1;
    #(CLK_P/4);
    chk("R11", "event wins over scan", 32'(dlv_num), 32'd20);
    chk("R11", "event dlv_valid", 32'(dlv_valid), 32'd1);
    @(posedge clk);
    #(CLK_P/4);
    idle_inputs();
    for (int k = 1; k < 10; k++) begin
      @(negedge clk);
      #(CLK_P/4);
      chk("R11", "stalled scan busy", 32'(busy), (k < 9) ? 32'd1 : 32'd0);
      chk("R6", "stalled scan dlv", 32'(dlv_valid), (k == 1 || k == 2) ? 32'd1 : 32'd0);
      if (k == 1) chk("R6", "level re-presented", 32'(dlv_num), 32'd16);
      if (k == 2) begin
        chk("R5", "rejected level re-presented", 32'(dlv_num), 32'd17);
        chk("R5", "rejected level prio", 32'(dlv_prio), 32'd16);
      end
    end

    // R1: pending state discarded by reset
    apply(ev(5, 1, 0, 0, 0, 0, 1));
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    #(CLK_P/4);
    chk("R1", "busy after reset", 32'(busy), 32'd0);
    chk("R1", "dlv after reset", 32'(dlv_valid), 32'd0);
    rst_n = 1'b1;
    apply(cm(1, 20, 0, 0, 0, 0, 0, 0, 0, 255, 1));
    apply(cm(0, 21, 0, 2, 0, 0, 0, 0, 0, 2, 1));
    apply(ev(5, 1, 0, 1, 21, 2, 3));

    finish_run();
  end
endmodule